// File: doc/BRIEF.md
# Serial Dot-Matrix Display Sequencer

This block drives a four-wire serial link to an LED dot-matrix display module: a register-select line, an active-low chip-enable, a serial clock and a serial data line. A one-cycle `start` pulse begins a complete update. The update has three segments: the first configuration byte, the second configuration byte, and a dot-data frame of `FRAME_BITS` bits. Each segment is framed by chip-enable and stored in the display by a single latch edge. The configuration bytes come from two host buses. Both are captured when `start` is accepted. Dot bits arrive one per transfer over a valid/ready stream.

The timing comes from a divider of `CLK_DIV` system cycles. Each sequencer step lasts one divider period: select, enable, clock low, clock high, enable release and latch. The data line changes only while the serial clock is low, so the display samples a settled bit on each rising clock edge. Configuration bytes go out most significant bit first. When the stream has no dot bit ready, the clock is held low until one arrives. `busy` covers the whole update. `done` marks the final latch.

States: `ST_IDLE` leaves on `start` to `ST_SEL`. `ST_SEL` drives register-select, then goes to `ST_ENA`, which drives chip-enable low. `ST_ENA` goes to `ST_LOW`. `ST_LOW` goes to `ST_HIGH` once its period is over and a bit is held. `ST_HIGH` returns to `ST_LOW`, or after the last bit goes to `ST_CEUP`, which raises chip-enable with the clock still high. `ST_CEUP` goes to `ST_LATCH`, where the clock falls. `ST_LATCH` then goes to `ST_SEL` for the next segment, or to `ST_IDLE` after the frame. The segment register steps `SEG_CW0` → `SEG_CW1` → `SEG_DOT`.

Top module: `dmd_serial_seq`

## Requirements
- R1: After reset: `rs_o`=0, `ce_n_o`=1, `sclk_o`=0, `sdo_o`=0, `bit_ready`=0, `busy`=0, `done`=0.
- R2: One update latches, in this order, the `cfg0` byte, the `cfg1` byte and then a frame of exactly `FRAME_BITS` bits. Each segment is latched exactly once.
- R3: For the two configuration segments `rs_o` is 1 before `ce_n_o` falls. For the frame, `rs_o` is 0 before `ce_n_o` falls. `rs_o` does not change while `ce_n_o` is 0.
- R4: `sdo_o` changes only while `sclk_o` is low. Configuration bytes are sent MSB first: bit 7 goes out on the first rising edge.
- R5: `ce_n_o` rises only while `sclk_o` is high. The next falling edge of `sclk_o` is the latch. A segment contains exactly 8 or `FRAME_BITS` rising edges.
- R6: Every high or low phase of `sclk_o` lasts at least `CLK_DIV` cycles. With the stream always valid, `done` is high in cycle 364·`CLK_DIV`−1 after the cycle in which `start` is accepted, where cycle 0 is the one right after that edge (727 for the default values).
- R7: `bit_ready` is high only during the frame, while `sclk_o` is low and no bit is held. If no bit is offered, `sclk_o` stays low.
- R8: `busy` is 1 from the cycle after `start` until the cycle that carries `done`. `done` lasts one cycle, and `busy` is 0 in the cycle after it.
- R9: A `start` during `busy` has no effect. Changes on `cfg0` or `cfg1` after `start` do not alter the bytes sent.
- R10: Frame bits go out in the order accepted: the first accepted bit is the first one shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update (ignored while busy) |
| cfg0 | input | 8 | First configuration byte (typically 0x4F) |
| cfg1 | input | 8 | Second configuration byte (typically 0x81) |
| bit_valid | input | 1 | Dot bit offered |
| bit_data | input | 1 | Dot bit value |
| bit_ready | output | 1 | Dot bit accepted when high with `bit_valid` |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse on the final latch |
| rs_o | output | 1 | Register-select: 1 for configuration, 0 for dot data |
| ce_n_o | output | 1 | Active-low chip-enable |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |

## Verification
`busy` is due one cycle after `start` is accepted. `done` is due exactly 364·`CLK_DIV`−1 cycles later when the stream never stalls, and `busy` falls in the cycle after `done`. The bench counts falling system-clock edges from the start edge and compares that count with the figure computed from the requirement. A display model samples all four pins once per cycle at the falling system-clock edge. It treats a change between two samples as an edge, so the shift, latch and setup rules are judged one full cycle after the registers that drive the pins have settled.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ENA,
        ST_LOW,
        ST_HIGH,
        ST_CEUP,
        ST_LATCH
    } dmd_state_t;

    typedef enum logic [1:0] {
        SEG_CW0,
        SEG_CW1,
        SEG_DOT
    } dmd_seg_t;
endpackage

// File: rtl/dmd_halfper.sv
module dmd_halfper #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/dmd_wordshift.sv
module dmd_wordshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign msb = sreg[W-1];
endmodule

// File: rtl/dmd_bitcount.sv
module dmd_bitcount #(
    parameter int MAX_N = 160
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       inc,
    input  logic [$clog2(MAX_N)-1:0]   limit,
    output logic                       last
);
    localparam int CW = $clog2(MAX_N);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == limit);
endmodule

// File: rtl/dmd_serial_seq.sv
module dmd_serial_seq
    import dmd_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int WORD_BITS  = 8,
    parameter int FRAME_BITS = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WORD_BITS-1:0] cfg0,
    input  logic [WORD_BITS-1:0] cfg1,
    input  logic                 bit_valid,
    input  logic                 bit_data,
    output logic                 bit_ready,
    output logic                 busy,
    output logic                 done,
    output logic                 rs_o,
    output logic                 ce_n_o,
    output logic                 sclk_o,
    output logic                 sdo_o
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LIM_WORD  = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] LIM_FRAME = CNT_W'(FRAME_BITS - 1);

    dmd_state_t state, nstate;
    dmd_seg_t   seg, nseg;

    logic                 tick;
    logic                 last_bit;
    logic                 word_msb;
    logic                 have_bit;
    logic                 dot_bit;
    logic [WORD_BITS-1:0] cfg1_q;
    logic                 step_clr;
    logic                 ws_load;
    logic                 ws_shift;
    logic                 bit_inc;
    logic [CNT_W-1:0]     bit_limit;

    // step timing
    dmd_halfper #(.DIV(CLK_DIV)) u_halfper (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .tick  (tick)
    );

    assign ws_load  = ((state == ST_IDLE) && start) ||
                      ((state == ST_LATCH) && tick && (seg == SEG_CW0));
    assign ws_shift = (state == ST_HIGH) && tick && !last_bit && (seg != SEG_DOT);

    dmd_wordshift #(.W(WORD_BITS)) u_wordshift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ws_load),
        .din   ((state == ST_IDLE) ? cfg0 : cfg1_q),
        .shift (ws_shift),
        .msb   (word_msb)
    );

    assign bit_inc   = (state == ST_HIGH) && tick;
    assign bit_limit = (seg == SEG_DOT) ? LIM_FRAME : LIM_WORD;

    dmd_bitcount #(.MAX_N(FRAME_BITS)) u_bitcount (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_SEL),
        .inc   (bit_inc),
        .limit (bit_limit),
        .last  (last_bit)
    );

    // next state
    always_comb begin
        nstate = state;
        nseg   = seg;
        unique case (state)
            ST_IDLE:  if (start) begin
                          nstate = ST_SEL;
                          nseg   = SEG_CW0;
                      end
            ST_SEL:   if (tick) nstate = ST_ENA;
            ST_ENA:   if (tick) nstate = ST_LOW;
            ST_LOW:   if (tick && ((seg != SEG_DOT) || have_bit)) nstate = ST_HIGH;
            ST_HIGH:  if (tick) nstate = last_bit ? ST_CEUP : ST_LOW;
            ST_CEUP:  if (tick) nstate = ST_LATCH;
            ST_LATCH: if (tick) begin
                          unique case (seg)
                              SEG_CW0: begin nstate = ST_SEL;  nseg = SEG_CW1; end
                              SEG_CW1: begin nstate = ST_SEL;  nseg = SEG_DOT; end
                              default: begin nstate = ST_IDLE; nseg = SEG_CW0; end
                          endcase
                      end
            default:  nstate = ST_IDLE;
        endcase
    end

    assign step_clr = (nstate != state);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            seg   <= SEG_CW0;
        end else begin
            state <= nstate;
            seg   <= nseg;
        end
    end

    // captured configuration and held dot bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1_q   <= '0;
            have_bit <= 1'b0;
            dot_bit  <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && start) cfg1_q <= cfg1;
            if ((state == ST_HIGH) && tick) begin
                have_bit <= 1'b0;
            end else if (bit_valid && bit_ready) begin
                have_bit <= 1'b1;
                dot_bit  <= bit_data;
            end
        end
    end

    // outputs
    always_comb begin
        rs_o      = 1'b0;
        ce_n_o    = 1'b1;
        sclk_o    = 1'b0;
        sdo_o     = 1'b0;
        bit_ready = 1'b0;
        busy      = (state != ST_IDLE);
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SEL:   rs_o = (seg != SEG_DOT);
            ST_ENA:   begin
                          rs_o   = (seg != SEG_DOT);
                          ce_n_o = 1'b0;
                      end
            ST_LOW:   begin
                          rs_o      = (seg != SEG_DOT);
                          ce_n_o    = 1'b0;
                          sdo_o     = (seg == SEG_DOT) ? dot_bit : word_msb;
                          bit_ready = (seg == SEG_DOT) && !have_bit;
                      end
            ST_HIGH:  begin
                          rs_o   = (seg != SEG_DOT);
                          ce_n_o = 1'b0;
                          sclk_o = 1'b1;
                          sdo_o  = (seg == SEG_DOT) ? dot_bit : word_msb;
                      end
            ST_CEUP:  begin
                          rs_o   = (seg != SEG_DOT);
                          sclk_o = 1'b1;
                          sdo_o  = (seg == SEG_DOT) ? dot_bit : word_msb;
                      end
            ST_LATCH: begin
                          rs_o = (seg != SEG_DOT);
                          done = tick && (seg == SEG_DOT);
                      end
            default:  ;
        endcase
    end

    // checks
    a_r4_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    a_r3_rs_hold_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_o && $past(!ce_n_o)) |-> $stable(rs_o));

    a_r5_ce_rise_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n_o) |-> sclk_o);

    a_r7_stall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ready && !bit_valid) |=> !sclk_o);

    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/dmd_serial_seq_tb.sv
module dmd_serial_seq_tb;
    localparam int DIV   = 2;
    localparam int FBITS = 160;
    localparam int LIM   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cfg0 = 8'h4F;
    logic [7:0] cfg1 = 8'h81;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       bit_ready, busy, done, rs_o, ce_n_o, sclk_o, sdo_o;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    // source state
    bit src_on = 1'b0;
    int src_mode = 0;
    bit src_gap = 1'b0;
    int src_idx = 0;
    int src_cyc = 0;

    // monitor state
    logic       p_sclk, p_ce, p_sdo, p_rs;
    logic       cur_rs;
    int         rxcnt, nlatch, viol_setup, viol_rs, viol_ce, viol_rdy, ndone;
    int         half_len, min_half;
    logic [0:FBITS-1] rxbits;
    logic [7:0] lw [0:3];
    logic       lrs [0:3];
    int         llen [0:3];
    logic [0:FBITS-1] lframe;

    always #4 clk = ~clk;

    dmd_serial_seq #(.CLK_DIV(DIV), .WORD_BITS(8), .FRAME_BITS(FBITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg0(cfg0), .cfg1(cfg1),
        .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
        .busy(busy), .done(done), .rs_o(rs_o), .ce_n_o(ce_n_o),
        .sclk_o(sclk_o), .sdo_o(sdo_o)
    );

    function automatic logic pat(input int mode, input int i);
        if (mode == 0) return logic'(i % 2);
        return ((i * 7) % 5) < 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic source_loop();
        forever begin
            @(negedge clk);
            src_cyc++;
            bit_valid = src_on && !(src_gap && ((src_cyc % 5) < 3));
            bit_data  = pat(src_mode, src_idx);
            if (bit_ready && bit_valid) src_idx++;
        end
    endtask

    task automatic mon_clear();
        rxcnt = 0; nlatch = 0; viol_setup = 0; viol_rs = 0; viol_ce = 0;
        viol_rdy = 0; ndone = 0; half_len = 0; min_half = 1000000;
    endtask

    task automatic monitor_loop();
        p_sclk = 1'b0; p_ce = 1'b1; p_sdo = 1'b0; p_rs = 1'b0; cur_rs = 1'b0;
        forever begin
            @(negedge clk);
            if (done) ndone++;
            if (bit_ready && sclk_o) viol_rdy++;
            if (sclk_o != p_sclk) begin
                if (half_len > 0 && half_len < min_half) min_half = half_len;
                half_len = 1;
            end else if (busy) begin
                half_len++;
            end
            if (p_ce && !ce_n_o) begin
                rxcnt = 0;
                cur_rs = rs_o;
                if (rs_o != p_rs) viol_rs++;
            end
            if (!ce_n_o && !p_ce && rs_o != p_rs) viol_rs++;
            if (p_sclk && sclk_o && sdo_o != p_sdo) viol_setup++;
            if (!ce_n_o && !p_sclk && sclk_o) begin
                if (sdo_o != p_sdo) viol_setup++;
                if (rxcnt < FBITS) rxbits[rxcnt] = sdo_o;
                rxcnt++;
            end
            if (!p_ce && ce_n_o && !sclk_o) viol_ce++;
            if (p_sclk && !sclk_o && ce_n_o) begin
                if (nlatch < 4) begin
                    lrs[nlatch]  = cur_rs;
                    llen[nlatch] = rxcnt;
                    for (int k = 0; k < 8; k++) lw[nlatch][7-k] = rxbits[k];
                end
                if (!cur_rs) lframe = rxbits;
                nlatch++;
            end
            p_sclk = sclk_o; p_ce = ce_n_o; p_sdo = sdo_o; p_rs = rs_o;
        end
    endtask

    // runs one update; returns cycles from start to done
    task automatic run_update(input int mode, input bit gap, input bit disturb,
                              output int ncyc);
        src_mode = mode; src_gap = gap; src_idx = 0; src_on = 1'b1;
        mon_clear();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        ncyc = 0;
        while (!done && ncyc < LIM) begin
            @(negedge clk);
            ncyc++;
            if (disturb && ncyc == 100) begin
                start = 1'b1; cfg0 = 8'hFF; cfg1 = 8'h00;
            end
            if (disturb && ncyc == 101) start = 1'b0;
        end
        chk(busy == 1'b1, "R8 busy during done", int'(busy), 1);
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle then idle", int'({done, busy}), 0);
        repeat (40) @(negedge clk);
        src_on = 1'b0;
    endtask

    task automatic check_update(input string name, input logic [7:0] e0,
                                input logic [7:0] e1, input int mode);
        int bad;
        chk(nlatch == 3, {"R2 latch count ", name}, nlatch, 3);
        chk(lrs[0] == 1'b1 && lrs[1] == 1'b1 && lrs[2] == 1'b0,
            {"R3 rs per segment ", name}, int'({lrs[0], lrs[1], lrs[2]}), 3'b110);
        chk(lw[0] == e0, {"R2 R4 word0 msb first ", name}, lw[0], e0);
        chk(lw[1] == e1, {"R2 R4 word1 msb first ", name}, lw[1], e1);
        chk(llen[0] == 8 && llen[1] == 8, {"R5 word edges ", name}, llen[0] * 256 + llen[1], 8 * 256 + 8);
        chk(llen[2] == FBITS, {"R5 frame edges ", name}, llen[2], FBITS);
        bad = 0;
        for (int i = 0; i < FBITS; i++) if (lframe[i] != pat(mode, i)) bad++;
        chk(bad == 0, {"R10 frame order ", name}, bad, 0);
        chk(viol_setup == 0, {"R4 data change while clk high ", name}, viol_setup, 0);
        chk(viol_rs == 0, {"R3 rs sequencing ", name}, viol_rs, 0);
        chk(viol_ce == 0, {"R5 ce rise with clk high ", name}, viol_ce, 0);
        chk(viol_rdy == 0, {"R7 ready only with clk low ", name}, viol_rdy, 0);
        chk(min_half >= DIV, {"R6 half period ", name}, min_half, DIV);
        chk(ndone == 1, {"R8 R9 single done ", name}, ndone, 1);
    endtask

    task automatic test_reset();
        chk(!rs_o && ce_n_o && !sclk_o && !sdo_o, "R1 pins idle",
            int'({rs_o, ce_n_o, sclk_o, sdo_o}), 4'b0100);
        chk(!bit_ready && !busy && !done, "R1 status idle",
            int'({bit_ready, busy, done}), 0);
    endtask

    task automatic test_default();
        int n;
        cfg0 = 8'h4F; cfg1 = 8'h81;
        run_update(0, 1'b0, 1'b0, n);
        chk(n == 364 * DIV - 1, "R6 duration no stall", n, 364 * DIV - 1);
        check_update("default", 8'h4F, 8'h81, 0);
    endtask

    task automatic test_stall();
        int n;
        cfg0 = 8'h35; cfg1 = 8'hC3;
        run_update(1, 1'b1, 1'b0, n);
        chk(n > 364 * DIV - 1, "R7 stall lengthens frame", n, 364 * DIV);
        check_update("stall", 8'h35, 8'hC3, 1);
    endtask

    task automatic test_ignore();
        int n;
        cfg0 = 8'hA6; cfg1 = 8'h59;
        run_update(0, 1'b0, 1'b1, n);
        chk(n == 364 * DIV - 1, "R9 start while busy no effect", n, 364 * DIV - 1);
        check_update("ignore", 8'hA6, 8'h59, 0);
        chk(!busy && ce_n_o && !sclk_o, "R9 no restart", int'({busy, ce_n_o, sclk_o}), 3'b010);
    endtask

    initial begin
        mon_clear();
        fork
            source_loop();
            monitor_loop();
        join_none
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        test_default();
        test_stall();
        test_ignore();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule